// File: doc/BRIEF.md
# Distributed Bus Arbitration Node

One copy of this block sits beside each of up to four processors that share an external bus. No central arbiter exists. Every processor pulls one active-low request line, and the lines combine as a wired-AND. Every node watches all four lines and runs the same ownership decision on the same clock edge. Because all copies see identical line values and start from an identical reset state, they all agree on who holds the bus. The processor whose node asserts `grant` may use the bus.

A strapped 3-bit identity chooses which line a node drives and which owner index it answers to. A strapped select input chooses the priority scheme. Fixed priority favours the lowest-numbered requester. Rotating priority begins its search one place after the most recent owner. Both straps are taken only while reset is held. A node with identity 000 works alone and always owns the bus. A node with a reserved identity stays off the lines and reports a configuration error.

Top module: `bus_arb_node`

## Requirements
- R1: `own_req_n` is 0 exactly when `local_req` is 1 and the captured identity is not reserved. Otherwise it is 1.
- R2: A captured identity k in 1..4 gives owner index k-1 (processors 1..4 map to owner codes 0..3). Line `bus_req_n[k-1]` is that node's line. `grant` is 1 exactly when the owner is valid and equals that index.
- R3: A captured identity of 5, 6 or 7 sets `cfg_err` to 1, holds `own_req_n` at 1 and holds `grant` at 0.
- R4: A captured identity of 000 makes the node its own single owner. After reset, `grant` is 1, `owner` is 0 and `owner_vld` is 1, whatever the inputs.
- R5: While the current owner's line is low, `owner` and `owner_vld` stay unchanged.
- R6: Only a low line counts as a request. When the owner has released its line and all lines are high, `owner_vld` falls to 0 on the next edge, and `owner` keeps the last owner.
- R7: With the captured select at 0 (fixed), an edge with no held owner makes the lowest-index low line the owner.
- R8: With the captured select at 1 (rotating), the search starts at the index after the last owner and wraps. Each of four continuous requesters wins once in turn.
- R9: After reset, `owner_vld` is 0 and `owner` is 3, so index 0 has top priority under rotation.
- R10: Identity and select are taken only on edges with `rst_n` low. Later changes have no effect.
- R11: In a system of nodes with identical captured configuration, at most one `grant` is 1 in any cycle. Ownership changes one clock after the line values that cause them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset; straps captured while low |
| strap_id | input | 3 | Processor identity strap |
| strap_rotate | input | 1 | 1 selects rotating priority, 0 fixed |
| local_req | input | 1 | This processor wants the bus |
| bus_req_n | input | 4 | All four wired-AND request lines, active low |
| own_req_n | output | 1 | Drive for this node's own request line |
| grant | output | 1 | This node owns the bus |
| owner | output | 2 | Index of current (or last) owner |
| owner_vld | output | 1 | Bus currently has an owner |
| cfg_err | output | 1 | Captured identity is reserved |

## Verification
Four nodes with identities 1 to 4 share a wired-AND bus. The bench runs random request patterns in fixed mode and in rotating mode. The owner is held until release, and requests arrive at random, which separates the two priority schemes from each other and from the hold rule. Directed runs with all four requesting and the owner briefly releasing show the exact fixed order (0,1,0) against the rotating order (0,1,2,3,0). Further runs cover a solo identity 000 with reserved neighbours, and straps changed after reset that must not alter the fixed order.

// File: rtl/arb_pkg.sv
// Shared definitions for the distributed arbitration node.
// Assumes: identity straps are decoded once into one of three classes.
package arb_pkg;
    typedef enum logic [1:0] {
        CFG_MULTI    = 2'd0,
        CFG_SOLO     = 2'd1,
        CFG_RESERVED = 2'd2
    } cfg_kind_e;
endpackage

// File: rtl/arb_cfg_latch.sv
// Decodes and captures the identity and priority straps.
// Assumes: straps are valid while rst_n is low; they are ignored afterwards.
module arb_cfg_latch #(
    parameter int NODES = 4,
    parameter int ID_W  = 3,
    localparam int IDX_W = $clog2(NODES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ID_W-1:0]      id_in,
    input  logic                 rot_in,
    output arb_pkg::cfg_kind_e   kind_q,
    output logic [IDX_W-1:0]     idx_q,
    output logic                 rot_q
);
    arb_pkg::cfg_kind_e kind_d;
    logic [IDX_W-1:0]   idx_d;

    // Classify the identity strap and derive the owner index.
    always_comb begin
        kind_d = arb_pkg::CFG_RESERVED;
        idx_d  = '0;
        if (id_in == '0) begin
            kind_d = arb_pkg::CFG_SOLO;
        end else if (id_in <= ID_W'(NODES)) begin
            kind_d = arb_pkg::CFG_MULTI;
            idx_d  = IDX_W'(id_in - 1'b1);
        end
    end

    // Capture only while reset is held, hold forever after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= kind_d;
            idx_q  <= idx_d;
            rot_q  <= rot_in;
        end
    end
endmodule

// File: rtl/arb_winner_pick.sv
// Circular priority search over the active request vector.
// Assumes: start is the index just before the highest-priority slot.
module arb_winner_pick #(
    parameter int NODES = 4,
    localparam int IDX_W = $clog2(NODES)
) (
    input  logic [NODES-1:0] active,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] win
);
    int pos;

    // Walk from start+1 around the ring, keep the first active slot.
    always_comb begin
        found = 1'b0;
        win   = '0;
        pos   = 0;
        for (int k = 1; k <= NODES; k++) begin
            pos = (int'(start) + k) % NODES;
            if (!found && active[pos]) begin
                found = 1'b1;
                win   = IDX_W'(pos);
            end
        end
    end
endmodule

// File: rtl/arb_owner_track.sv
// Holds this node's copy of the bus owner and updates it on release.
// Assumes: every node sees the same line values on the same edge.
module arb_owner_track #(
    parameter int NODES = 4,
    localparam int IDX_W = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] active,
    input  logic             rotate,
    output logic [IDX_W-1:0] owner_q,
    output logic             busy_q
);
    logic             found;
    logic [IDX_W-1:0] win;
    logic [IDX_W-1:0] start;

    // Fixed mode always starts after the top index; rotating after last owner.
    always_comb start = rotate ? owner_q : IDX_W'(NODES - 1);

    arb_winner_pick #(.NODES(NODES)) u_pick (
        .active (active),
        .start  (start),
        .found  (found),
        .win    (win)
    );

    // Keep the owner while its line is low, otherwise hand over or go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= IDX_W'(NODES - 1);
            busy_q  <= 1'b0;
        end else if (busy_q && active[owner_q]) begin
            busy_q  <= 1'b1;
        end else if (found) begin
            owner_q <= win;
            busy_q  <= 1'b1;
        end else begin
            busy_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_arb_node.sv
// One node of a distributed arbiter over wired-AND active-low request lines.
// Assumes: all nodes share clock, reset and the same rotate strap.
module bus_arb_node #(
    parameter int NODES = 4,
    parameter int ID_W  = 3,
    localparam int IDX_W = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  strap_id,
    input  logic             strap_rotate,
    input  logic             local_req,
    input  logic [NODES-1:0] bus_req_n,
    output logic             own_req_n,
    output logic             grant,
    output logic [IDX_W-1:0] owner,
    output logic             owner_vld,
    output logic             cfg_err
);
    arb_pkg::cfg_kind_e cfg_kind_q;
    logic [IDX_W-1:0]   cfg_idx_q;
    logic               cfg_rot_q;
    logic [IDX_W-1:0]   trk_owner;
    logic               trk_busy;
    logic               solo;

    arb_cfg_latch #(.NODES(NODES), .ID_W(ID_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .id_in  (strap_id),
        .rot_in (strap_rotate),
        .kind_q (cfg_kind_q),
        .idx_q  (cfg_idx_q),
        .rot_q  (cfg_rot_q)
    );

    arb_owner_track #(.NODES(NODES)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (~bus_req_n),
        .rotate  (cfg_rot_q),
        .owner_q (trk_owner),
        .busy_q  (trk_busy)
    );

    // Decode the configuration class into simple flags.
    always_comb begin
        solo    = (cfg_kind_q == arb_pkg::CFG_SOLO);
        cfg_err = (cfg_kind_q == arb_pkg::CFG_RESERVED);
    end

    // Drive the own line only with a legal identity.
    always_comb own_req_n = ~(local_req & ~cfg_err);

    // Present ownership; a solo node is permanently the owner.
    always_comb begin
        owner     = solo ? '0 : trk_owner;
        owner_vld = solo | trk_busy;
        grant     = solo | ((cfg_kind_q == arb_pkg::CFG_MULTI) && trk_busy
                            && (trk_owner == cfg_idx_q));
    end
endmodule

// File: rtl/arb_node_chk.sv
// Property checker for one arbitration node, bound to bus_arb_node.
// Assumes: observes ports plus the decoded solo flag.
module arb_node_chk #(
    parameter int NODES = 4,
    localparam int IDX_W = $clog2(NODES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             local_req,
    input logic [NODES-1:0] bus_req_n,
    input logic             own_req_n,
    input logic             grant,
    input logic [IDX_W-1:0] owner,
    input logic             owner_vld,
    input logic             cfg_err,
    input logic             solo
);
    // R3
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (own_req_n && !grant));

    // R1
    drive_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_err && local_req) |-> !own_req_n);

    // R4
    solo_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        solo |-> (grant && owner_vld && owner == '0));

    // R5
    hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!solo && owner_vld && !bus_req_n[owner]) |=> (owner_vld && owner == $past(owner)));

    // R6
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!solo && (&bus_req_n)) |=> !owner_vld);

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(cfg_err) && $stable(solo)));
endmodule

bind bus_arb_node arb_node_chk #(.NODES(NODES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .local_req (local_req),
    .bus_req_n (bus_req_n),
    .own_req_n (own_req_n),
    .grant     (grant),
    .owner     (owner),
    .owner_vld (owner_vld),
    .cfg_err   (cfg_err),
    .solo      (cfg_kind_q == arb_pkg::CFG_SOLO)
);

// File: tb/bus_arb_node_bench.sv
module bus_arb_node_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ids [N];
    logic [2:0] wired_id [N];
    logic       rot = 1'b0;
    logic [N-1:0] lreq = '0;
    logic [N-1:0] drv_n, grant, ovld, err;
    logic [1:0]   own [N];
    logic [N-1:0] bus_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [1:0] m_own;
    logic       m_vld;
    bit         model_on;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Wired-AND bus from bench-known strapping.
    always_comb begin
        bus_n = '1;
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                if ((wired_id[i] == 3'(j + 1)) || (wired_id[i] == 3'd0 && j == 0))
                    bus_n[j] = bus_n[j] & drv_n[i];
    end

    for (genvar g = 0; g < N; g++) begin : g_node
        bus_arb_node u_bus_arb_node (
            .clk          (clk),
            .rst_n        (rst_n),
            .strap_id     (ids[g]),
            .strap_rotate (rot),
            .local_req    (lreq[g]),
            .bus_req_n    (bus_n),
            .own_req_n    (drv_n[g]),
            .grant        (grant[g]),
            .owner        (own[g]),
            .owner_vld    (ovld[g]),
            .cfg_err      (err[g])
        );
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pick(input logic [N-1:0] act, input int start);
        for (int k = 1; k <= N; k++)
            if (act[(start + k) % N]) return (start + k) % N;
        return -1;
    endfunction

    task automatic model_step(input bit rmode);
        int w;
        logic [N-1:0] act;
        act = ~bus_n;
        if (!(m_vld && act[m_own])) begin
            w = pick(act, rmode ? int'(m_own) : N - 1);
            if (w >= 0) begin m_own = 2'(w); m_vld = 1'b1; end
            else m_vld = 1'b0;
        end
    endtask

    // Compare all four nodes against the model (identities 1..4).
    task automatic check_model();
        for (int i = 0; i < N; i++) begin
            chk(grant[i] == (m_vld && m_own == 2'(i)), "R2 grant", grant[i], int'(m_vld && m_own == 2'(i)));
            chk(ovld[i] == m_vld, "R5/R6 owner_vld", ovld[i], m_vld);
            chk(own[i] == m_own, "R7/R8 owner", own[i], m_own);
        end
        chk($countones(grant) <= 1, "R11 mutual exclusion", $countones(grant), 1);
    endtask

    task automatic cycle(input logic [N-1:0] nreq, input bit rmode);
        lreq = nreq;
        @(posedge clk);
        if (model_on) model_step(rmode);
        @(negedge clk);
        if (model_on) check_model();
    endtask

    task automatic do_reset(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                            input logic [2:0] d, input logic r);
        @(negedge clk);
        rst_n = 1'b0;
        lreq = '0;
        ids[0] = a; ids[1] = b; ids[2] = c; ids[3] = d;
        wired_id[0] = a; wired_id[1] = b; wired_id[2] = c; wired_id[3] = d;
        rot = r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_own = 2'd3;
        m_vld = 1'b0;
    endtask

    task automatic random_run(input bit rmode, input int n);
        logic [N-1:0] nr;
        for (int c = 0; c < n; c++) begin
            nr = lreq;
            for (int i = 0; i < N; i++) begin
                if (m_vld && m_own == 2'(i) && lreq[i]) begin
                    if ($urandom_range(2) == 0) nr[i] = 1'b0;
                end else if (!lreq[i]) begin
                    nr[i] = ($urandom_range(1) == 1);
                end
            end
            cycle(nr, rmode);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int exp_o;
        void'($urandom(32'd20240517));
        model_on = 1'b0;
        for (int i = 0; i < N; i++) begin ids[i] = 3'(i + 1); wired_id[i] = 3'(i + 1); end

        // R9: reset state
        do_reset(3'd1, 3'd2, 3'd3, 3'd4, 1'b1);
        for (int i = 0; i < N; i++) begin
            chk(!ovld[i] && own[i] == 2'd3 && !grant[i], "R9 reset state", {ovld[i], own[i]}, 3);
            chk(!err[i] && drv_n[i], "R1 idle drive", drv_n[i], 1);
        end

        // R8: rotating fairness, all four requesting, owner releases briefly
        cycle(4'hF, 1'b1);
        chk(own[2] == 2'd0 && grant[0], "R8 first winner", own[2], 0);
        exp_o = 0;
        for (int k = 1; k <= 4; k++) begin
            cycle(4'hF & ~(4'b1 << exp_o), 1'b1);
            exp_o = (exp_o + 1) % N;
            chk(own[1] == 2'(exp_o) && grant[exp_o] && $countones(grant) == 1,
                "R8 rotation order", own[1], exp_o);
            cycle(4'hF, 1'b1);
            chk(own[3] == 2'(exp_o), "R5 hold while low", own[3], exp_o);
        end

        // R6: all release
        cycle(4'h0, 1'b1);
        chk(!ovld[0] && own[0] == 2'(exp_o), "R6 idle keeps last", {ovld[0], own[0]}, exp_o);

        // R7 and R10: fixed mode, straps disturbed after reset
        do_reset(3'd1, 3'd2, 3'd3, 3'd4, 1'b0);
        ids[0] = 3'd7;
        rot = 1'b1;
        cycle(4'hF, 1'b0);
        chk(grant[0] && !err[0], "R10 straps ignored", grant[0], 1);
        chk(!drv_n[0], "R1 drive low", drv_n[0], 0);
        cycle(4'hE, 1'b0);
        chk(own[2] == 2'd1, "R7 fixed next lowest", own[2], 1);
        cycle(4'hD, 1'b0);
        chk(own[2] == 2'd0, "R7 fixed returns to 0 (R10 rotate ignored)", own[2], 0);
        cycle(4'h0, 1'b0);
        ids[0] = 3'd1;
        rot = 1'b0;

        // Random runs in both modes against the model
        do_reset(3'd1, 3'd2, 3'd3, 3'd4, 1'b0);
        model_on = 1'b1;
        random_run(1'b0, 400);
        model_on = 1'b0;
        do_reset(3'd1, 3'd2, 3'd3, 3'd4, 1'b1);
        model_on = 1'b1;
        random_run(1'b1, 400);
        model_on = 1'b0;

        // R4 and R3: solo node with reserved neighbours
        do_reset(3'd0, 3'd5, 3'd6, 3'd7, 1'b0);
        chk(grant[0] && ovld[0] && own[0] == 2'd0, "R4 solo owner", grant[0], 1);
        cycle(4'hE, 1'b0);
        for (int i = 1; i < N; i++) begin
            chk(err[i], "R3 cfg_err", err[i], 1);
            chk(drv_n[i] && !grant[i], "R3 no drive", drv_n[i], 1);
        end
        chk(bus_n == 4'hF && grant[0], "R4 solo grant without request", bus_n, 15);
        cycle(4'h1, 1'b0);
        chk(bus_n == 4'hE && grant[0] && own[0] == 2'd0, "R4 solo with request", bus_n, 14);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule